// File: doc/BRIEF.md
# Dual-Converter Serial Result Sequencer

This block models the digital side of a converter with two channels that sample at the same instant. A rising edge on the start input begins a conversion, and this start is followed by a fixed busy window. The block decides which of the two input pairs is converted. It then holds the two 12-bit results, one from converter A and one from converter B, which arrive on parallel input ports. A falling edge on the read strobe later launches a framed serial transfer of the held results.

Two mode inputs set how the block works:

- **Pair selection.** In two-channel mode the address input picks the pair. The address sampled at one accepted start applies to the following conversion. In four-channel mode the address is ignored, and the pair toggles on every accepted conversion.
- **Output lines.** In dual-line mode converter A's word leaves on line A while converter B's word leaves on line B. In single-line mode both words leave back to back on line A, and line B stops being driven. Because two words take twice as long, every second start command is dropped in this mode.

Each serial pin is modelled as a data bit plus an output-enable bit.

Top module: `adcseq_top`

## Requirements
- R1: A rising edge on `start_i`, seen at a clock edge while the block is free, is accepted at that edge. `busy_o` is then high for exactly 16 cycles, beginning after that edge.
- R2: Each 16-bit word is sent MSB first in this bit order: pair flag (0 = pair 0, 1 = pair 1), converter flag (0 = A, 1 = B), the 12 data bits from bit 11 down to bit 0, and two zero bits.
- R3: With `quad_i` low, a conversion uses the pair held in a next-pair register. That register is 0 after reset and is loaded from `addr_i` at each accepted start. Pair 0 means A0/B0 and pair 1 means A1/B1.
- R4: With `quad_i` high, `addr_i` has no effect. The next-pair register inverts at every accepted start, so a run starting from reset converts pair 0, then 1, then 0.
- R5: When the accepted conversion had `single_i` low, a frame is 16 bits long. The A word is on `sda_o` and the B word is on `sdb_o` in the same cycles.
- R6: When the accepted conversion had `single_i` high, `sda_o` carries the A word followed by the B word, 32 bits in all. `sdb_oe_o` stays high until the first conversion accepted with `single_i` high, and is low after it.
- R7: With `single_i` high, a start that arrives before 32 cycles have passed since the accepted start is ignored. A start repeated every 16 cycles is therefore accepted only on every second command.
- R8: With `single_i` low, a start that arrives while `busy_o` is high, before the last busy cycle, is ignored. The held results and the pair stay unchanged.
- R9: While `cs_n_i` is high, `sda_oe_o` and `sdb_oe_o` are both low. While it is low, `sda_oe_o` is high.
- R10: The first frame bit appears after the third rising edge that sees `rd_n_i` low, counting the edge that first sees it low. Outside a frame, `sda_o` is 0.
- R11: Data values pass through as two's complement without change: 0x7FF (positive full scale), 0x800 (negative full scale) and 0x000 (midscale).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-conversion strobe (rising edge) |
| rd_n_i | input | 1 | Read strobe, falling edge launches a frame |
| cs_n_i | input | 1 | Active-low output enable for both lines |
| quad_i | input | 1 | 1 = four-channel automatic pair toggling |
| single_i | input | 1 | 1 = both words on line A |
| addr_i | input | 1 | Pair address for two-channel mode |
| a0_data_i | input | 12 | Converter A result, pair 0 |
| a1_data_i | input | 12 | Converter A result, pair 1 |
| b0_data_i | input | 12 | Converter B result, pair 0 |
| b1_data_i | input | 12 | Converter B result, pair 1 |
| sda_o | output | 1 | Line A serial data |
| sda_oe_o | output | 1 | Line A drive enable |
| sdb_o | output | 1 | Line B serial data |
| sdb_oe_o | output | 1 | Line B drive enable |
| busy_o | output | 1 | Conversion in progress |

## Verification
A wrong pair register shows up as a wrong flag in the first bit of the next frame, and as data from the other pair. A stale lock counter shows as `busy_o` rising again on a start that should have been dropped, visible one cycle after that start. A fault in the frame counter or the shift register corrupts the bit order or the frame length within the frame it affects, and the read-latency count shows in the very first sampled bit. The bench drives each mode, drops starts at the edge of the lock window, and reads back every frame bit by bit.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Pair used by the conversion after the current one.
  function automatic logic next_pair(input logic quad, input logic addr, input logic cur);
    return quad ? ~cur : addr;
  endfunction

  // Cycles during which further start commands are refused.
  function automatic int unsigned lock_span(input logic single, input int unsigned conv);
    return single ? 2 * conv : conv;
  endfunction

endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              quad_i,
  input  logic              single_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] a0_i,
  input  logic [DATA_W-1:0] a1_i,
  input  logic [DATA_W-1:0] b0_i,
  input  logic [DATA_W-1:0] b1_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              single_lat_o,
  output logic              held_pair_o,
  output logic [DATA_W-1:0] held_a_o,
  output logic [DATA_W-1:0] held_b_o
);
  localparam int LOCK_W = $clog2(2 * CONV_CYCLES + 1);

  logic              start_q;
  logic              nxt_pair;
  logic [LOCK_W-1:0] lock_cnt;
  logic [LOCK_W-1:0] conv_cnt;
  logic              start_rise;

  assign start_rise = start_i & ~start_q;
  // Free when no lock is left beyond the final cycle.
  assign accept_o   = start_rise & (lock_cnt < LOCK_W'(2));
  assign busy_o     = (conv_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q      <= 1'b0;
      nxt_pair     <= 1'b0;
      lock_cnt     <= '0;
      conv_cnt     <= '0;
      single_lat_o <= 1'b0;
      held_pair_o  <= 1'b0;
      held_a_o     <= '0;
      held_b_o     <= '0;
    end else begin
      start_q <= start_i;
      if (accept_o) begin
        conv_cnt     <= LOCK_W'(CONV_CYCLES);
        lock_cnt     <= LOCK_W'(lock_span(single_i, CONV_CYCLES));
        held_pair_o  <= nxt_pair;
        nxt_pair     <= next_pair(quad_i, addr_i, nxt_pair);
        held_a_o     <= nxt_pair ? a1_i : a0_i;
        held_b_o     <= nxt_pair ? b1_i : b0_i;
        single_lat_o <= single_i;
      end else begin
        if (conv_cnt != '0) conv_cnt <= conv_cnt - 1'b1;
        if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
      end
    end
  end

  // R1: an accepted start raises busy at the next cycle
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o);

  // R7 / R8: a refused start leaves the held results untouched
  a_r8_refused_start_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rise && !accept_o) |=> ($stable(held_a_o) && $stable(held_b_o) && $stable(held_pair_o)));

endmodule

// File: rtl/adcseq_shift.sv
module adcseq_shift #(
  parameter int DATA_W   = 12,
  parameter int READ_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n_i,
  input  logic              single_lat_i,
  input  logic              held_pair_i,
  input  logic [DATA_W-1:0] held_a_i,
  input  logic [DATA_W-1:0] held_b_i,
  output logic              sda_bit_o,
  output logic              sdb_bit_o
);
  localparam int WORD_W = DATA_W + 4;
  localparam int CNT_W  = $clog2(2 * WORD_W + 1);
  localparam int PEND_W = $clog2(READ_LAT + 1);

  function automatic logic [WORD_W-1:0] fmt_word(input logic pair, input logic conv_b,
                                                 input logic [DATA_W-1:0] data);
    return {pair, conv_b, data, 2'b00};
  endfunction

  logic                  rd_q;
  logic [PEND_W-1:0]     pend;
  logic [CNT_W-1:0]      bits_left;
  logic [2*WORD_W-1:0]   shift_a;
  logic [WORD_W-1:0]     shift_b;
  logic                  rd_fall;
  logic                  launch;
  logic [WORD_W-1:0]     word_a;
  logic [WORD_W-1:0]     word_b;

  assign rd_fall = rd_q & ~rd_n_i;
  assign launch  = (pend == PEND_W'(1));
  assign word_a  = fmt_word(held_pair_i, 1'b0, held_a_i);
  assign word_b  = fmt_word(held_pair_i, 1'b1, held_b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b1;
      pend      <= '0;
      bits_left <= '0;
      shift_a   <= '0;
      shift_b   <= '0;
    end else begin
      rd_q <= rd_n_i;
      if (rd_fall)          pend <= PEND_W'(READ_LAT - 1);
      else if (pend != '0)  pend <= pend - 1'b1;

      if (launch) begin
        shift_a   <= single_lat_i ? {word_a, word_b} : {word_a, {WORD_W{1'b0}}};
        shift_b   <= word_b;
        bits_left <= single_lat_i ? CNT_W'(2 * WORD_W) : CNT_W'(WORD_W);
      end else if (bits_left != '0) begin
        shift_a   <= {shift_a[2*WORD_W-2:0], 1'b0};
        shift_b   <= {shift_b[WORD_W-2:0], 1'b0};
        bits_left <= bits_left - 1'b1;
      end
    end
  end

  assign sda_bit_o = (bits_left != '0) & shift_a[2*WORD_W-1];
  assign sdb_bit_o = (bits_left != '0) & shift_b[WORD_W-1];

  // R2: the two closing bits of every frame are zero
  a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_left == CNT_W'(1) || bits_left == CNT_W'(2)) |-> !sda_bit_o);

  // R10: no frame bit leaves while the read latency is still counting
  a_r10_quiet_before_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall && bits_left == '0) |=> !sda_bit_o);

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 16,
  parameter int READ_LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_n_i,
  input  logic              cs_n_i,
  input  logic              quad_i,
  input  logic              single_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] a0_data_i,
  input  logic [DATA_W-1:0] a1_data_i,
  input  logic [DATA_W-1:0] b0_data_i,
  input  logic [DATA_W-1:0] b1_data_i,
  output logic              sda_o,
  output logic              sda_oe_o,
  output logic              sdb_o,
  output logic              sdb_oe_o,
  output logic              busy_o
);
  logic              accept;
  logic              single_lat;
  logic              held_pair;
  logic [DATA_W-1:0] held_a;
  logic [DATA_W-1:0] held_b;

  adcseq_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .quad_i       (quad_i),
    .single_i     (single_i),
    .addr_i       (addr_i),
    .a0_i         (a0_data_i),
    .a1_i         (a1_data_i),
    .b0_i         (b0_data_i),
    .b1_i         (b1_data_i),
    .accept_o     (accept),
    .busy_o       (busy_o),
    .single_lat_o (single_lat),
    .held_pair_o  (held_pair),
    .held_a_o     (held_a),
    .held_b_o     (held_b)
  );

  adcseq_shift #(.DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_n_i       (rd_n_i),
    .single_lat_i (single_lat),
    .held_pair_i  (held_pair),
    .held_a_i     (held_a),
    .held_b_i     (held_b),
    .sda_bit_o    (sda_o),
    .sdb_bit_o    (sdb_o)
  );

  assign sda_oe_o = ~cs_n_i;
  assign sdb_oe_o = ~cs_n_i & ~single_lat;

  // R6: a conversion accepted in single-line mode releases line B
  a_r6_b_released: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && single_i) |=> !sdb_oe_o);

endmodule

// File: tb/sim_adcseq_top.sv
module sim_adcseq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, rd_n_i = 1'b1, cs_n_i = 1'b1;
  logic quad_i = 1'b0, single_i = 1'b0, addr_i = 1'b0;
  logic [11:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic sda_o, sda_oe_o, sdb_o, sdb_oe_o, busy_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  bit m_nxt = 1'b0;

  always #2 clk = ~clk;

  adcseq_top u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_n_i(rd_n_i), .cs_n_i(cs_n_i),
    .quad_i(quad_i), .single_i(single_i), .addr_i(addr_i),
    .a0_data_i(a0), .a1_data_i(a1), .b0_data_i(b0), .b1_data_i(b1),
    .sda_o(sda_o), .sda_oe_o(sda_oe_o), .sdb_o(sdb_o), .sdb_oe_o(sdb_oe_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word16(input bit pair, input bit conv_b, input logic [11:0] d);
    return 16'((int'(pair) * 32768) + (int'(conv_b) * 16384) + int'(d) * 4);
  endfunction

  // Driver: pulses start; on an expected accept, pushes the words it predicts.
  task automatic convert(input bit acc, input bit addr, input logic [11:0] d_a0, d_a1, d_b0, d_b1);
    @(negedge clk);
    a0 = d_a0; a1 = d_a1; b0 = d_b0; b1 = d_b1; addr_i = addr;
    start_i = 1'b1;
    if (acc) begin
      exp_q.push_back(word16(m_nxt, 1'b0, m_nxt ? d_a1 : d_a0));
      exp_q.push_back(word16(m_nxt, 1'b1, m_nxt ? d_b1 : d_b0));
      m_nxt = quad_i ? ~m_nxt : addr;
    end
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // Monitor: launches a read, collects the frame and compares against the queue.
  task automatic read_frame(input bit two_words, input string req);
    logic [31:0] got_a;
    logic [15:0] got_b;
    logic [15:0] ea, eb;
    int len;
    bit b_driven;
    len = two_words ? 32 : 16;
    got_a = '0; got_b = '0; b_driven = 1'b0;
    @(negedge clk);
    rd_n_i = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R10 line idle before third edge", 32'(sda_o), 32'd0);
    rd_n_i = 1'b1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      got_a = {got_a[30:0], sda_o};
      if (i < 16) got_b = {got_b[14:0], sdb_o};
      if (sdb_oe_o) b_driven = 1'b1;
    end
    ea = exp_q.pop_front();
    eb = exp_q.pop_front();
    if (two_words) begin
      chk({req, " R6 single-line A then B"}, got_a, {ea, eb});
      chk("R6 line B released", 32'(b_driven), 32'd0);
    end else begin
      chk({req, " R5 line A word"}, got_a, 32'(ea));
      chk({req, " R5 line B word"}, 32'(got_b), 32'(eb));
    end
    @(negedge clk);
    chk("R10 line idle after frame", 32'(sda_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset busy", 32'(busy_o), 32'd0);
    chk("R9 reset cs high A off", 32'(sda_oe_o), 32'd0);
    chk("R9 reset cs high B off", 32'(sdb_oe_o), 32'd0);
    chk("reset line idle", 32'(sda_o), 32'd0);
    cs_n_i = 1'b0;
    @(negedge clk);
    chk("R9 cs low A on", 32'(sda_oe_o), 32'd1);
    chk("R9 cs low B on", 32'(sdb_oe_o), 32'd1);

    // R1 busy window, R3 address latency (first conversion pair 0 despite addr 1)
    convert(1'b1, 1'b1, 12'h123, 12'h456, 12'h789, 12'hABC);
    cnt = 0;
    while (busy_o && cnt < 40) begin cnt++; @(negedge clk); end
    chk("R1 busy length", 32'(cnt), 32'd16);
    read_frame(1'b0, "R3 pair0 R2");
    convert(1'b1, 1'b0, 12'h111, 12'h7FF, 12'h222, 12'h800);
    read_frame(1'b0, "R3 pair1 R11 full scale");
    convert(1'b1, 1'b0, 12'h000, 12'h333, 12'hFFF, 12'h444);
    read_frame(1'b0, "R3 pair0 R11 midscale");

    // R8 start during busy ignored
    convert(1'b1, 1'b1, 12'h5A5, 12'h0F0, 12'hA5A, 12'h00F);
    repeat (3) @(negedge clk);
    convert(1'b0, 1'b0, 12'h666, 12'h666, 12'h666, 12'h666);
    chk("R8 busy still from first start", 32'(busy_o), 32'd1);
    repeat (20) @(negedge clk);
    read_frame(1'b0, "R8 held data kept");

    // R4 four-channel: addr ignored, pairs alternate
    quad_i = 1'b1;
    convert(1'b1, 1'b0, 12'h101, 12'h202, 12'h303, 12'h404);
    read_frame(1'b0, "R4 first");
    convert(1'b1, 1'b0, 12'h505, 12'h606, 12'h707, 12'h7F0);
    read_frame(1'b0, "R4 second");
    convert(1'b1, 1'b1, 12'h818, 12'h929, 12'hA3A, 12'hB4B);
    read_frame(1'b0, "R4 third");
    quad_i = 1'b0;

    // R6 line B released only from the next conversion
    single_i = 1'b1;
    @(negedge clk);
    chk("R6 B still driven before conversion", 32'(sdb_oe_o), 32'd1);
    convert(1'b1, 1'b0, 12'hC0C, 12'hD0D, 12'hE0E, 12'h0E0);
    chk("R6 B released after conversion", 32'(sdb_oe_o), 32'd0);
    // R7 second start 16 cycles later ignored
    repeat (14) @(negedge clk);
    convert(1'b0, 1'b1, 12'h999, 12'h999, 12'h999, 12'h999);
    chk("R7 second start ignored", 32'(busy_o), 32'd0);
    read_frame(1'b1, "R7 first data kept");
    convert(1'b1, 1'b0, 12'h7FF, 12'h001, 12'h800, 12'h002);
    read_frame(1'b1, "R11 single-line");

    // R9 cs high disables both lines
    cs_n_i = 1'b1;
    @(negedge clk);
    chk("R9 cs high A off", 32'(sda_oe_o), 32'd0);
    chk("R9 cs high B off", 32'(sdb_oe_o), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule